// File: doc/BRIEF.md
# Call and return frame sequencer

This block carries out the stack side of a subroutine call, a subroutine return and a system-call trap entry. It runs as a multi-cycle state machine behind a single-word memory port. The pipeline hands it the current stack pointer, frame pointer and instruction address through dedicated inputs along with a one-cycle start strobe. When the sequence ends, the block returns the new stack pointer, frame pointer and program counter, qualified by a one-cycle done pulse.

Every frame has three words. The highest is a reserved slot that is never written. Below it is the return address, and the old frame pointer sits at the bottom. On a call, the return address is pushed first and the saved frame pointer second. The stack pointer and the frame pointer then both point at the saved frame pointer, and the program counter moves to the call target. A return reads the two stored words back and steps the stack pointer over the whole frame. A trap builds the same frame as a call but jumps to a handler address taken from a special register. Instruction decode and the general register file lie outside this block.

Top module: `call_frame_seq`

## Requirements
- R1: While reset is held and after it is released, done_o is 0, mem_req_o is 0, and sp_o, fp_o and pc_o are all 0.
- R2: The first access of a call or trap is a write of the return address to stack pointer minus 8. No access ever goes to stack pointer minus 4.
- R3: The second access of a call or trap is a write of the old frame pointer to stack pointer minus 12.
- R4: Kind encoding on kind_i: 2'b00 is a register-indirect call, 2'b01 is an absolute call, 2'b10 is a trap and 2'b11 is a return. The return address is pc_i plus 2 for 2'b00, and pc_i plus 6 for 2'b01 and 2'b10.
- R5: After a call or trap, sp_o and fp_o both equal stack pointer minus 12. pc_o equals target_i for a call and handler_i for a trap.
- R6: A return makes only reads: first at the frame pointer, then at the frame pointer plus 4. Afterwards fp_o is the first word read, pc_o is the second word read, and sp_o is the old frame pointer plus 12.
- R7: A request holds its address, write enable and write data unchanged until mem_ready_i accepts it. The sequence does not advance without that acceptance.
- R8: done_o is high for exactly one cycle per accepted start. That cycle immediately follows the cycle in which the final access is accepted, and the new register values are valid in it.
- R9: A start that arrives while a sequence is in progress, including in its done cycle, is ignored. It produces no access and no done pulse.
- R10: kind_i, pc_i, sp_i, fp_i, target_i and handler_i are sampled only in the cycle a start is accepted. Later changes to them do not affect the sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a sequence (accepted only when idle) |
| kind_i | input | 2 | Sequence kind: 00 reg call, 01 abs call, 10 trap, 11 return |
| pc_i | input | 32 | Address of the call or trap instruction |
| sp_i | input | 32 | Current stack pointer |
| fp_i | input | 32 | Current frame pointer |
| target_i | input | 32 | Call destination |
| handler_i | input | 32 | Trap handler address (special register 1) |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write enable for the access |
| mem_addr_o | output | 32 | Byte address of the word |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid while mem_ready_i is high |
| mem_ready_i | input | 1 | Access accepted this cycle |
| done_o | output | 1 | One-cycle completion pulse |
| sp_o | output | 32 | Updated stack pointer |
| fp_o | output | 32 | Updated frame pointer |
| pc_o | output | 32 | Updated program counter |

## Verification
Two things can land in the same cycle. One is a fresh start strobe and the done pulse of the sequence still finishing. The other is a new request and its acceptance, when memory answers with no wait state. The bench raises start exactly in the done cycle, using a different kind. The cycle after, it requires mem_req_o and done_o to stay low, and at the end it requires the done count and the access scoreboard to match only the accepted starts. Runs with ready held high check that a zero-wait access is taken in the cycle it is issued, and that the two pushes still go to the expected addresses in order.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;
  typedef enum logic [1:0] {
    KIND_CALL_REG = 2'b00,
    KIND_CALL_ABS = 2'b01,
    KIND_TRAP     = 2'b10,
    KIND_RET      = 2'b11
  } frame_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_ACC0 = 2'b01,
    ST_ACC1 = 2'b10,
    ST_DONE = 2'b11
  } frame_state_e;
endpackage

// File: rtl/frame_calc.sv
module frame_calc
  import frame_seq_pkg::*;
#(
  parameter int DW         = 32,
  parameter int WORD_BYTES = 4,
  parameter int SHORT_LEN  = 2,
  parameter int LONG_LEN   = 6
) (
  input  frame_kind_e   kind_i,
  input  logic          phase_i,
  input  logic [DW-1:0] pc_i,
  input  logic [DW-1:0] sp_i,
  input  logic [DW-1:0] fp_i,
  output logic          is_ret_o,
  output logic          we_o,
  output logic [DW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] frame_top_o,
  output logic [DW-1:0] unwind_sp_o
);
  localparam logic [DW-1:0] STEP   = DW'(WORD_BYTES);
  localparam logic [DW-1:0] STEP2  = DW'(2 * WORD_BYTES);
  localparam logic [DW-1:0] FRAME  = DW'(3 * WORD_BYTES);
  localparam logic [DW-1:0] SHORTL = DW'(SHORT_LEN);
  localparam logic [DW-1:0] LONGL  = DW'(LONG_LEN);

  logic [DW-1:0] ret_addr;

  always_comb begin
    is_ret_o    = (kind_i == KIND_RET);
    ret_addr    = pc_i + ((kind_i == KIND_CALL_REG) ? SHORTL : LONGL);
    frame_top_o = sp_i - FRAME;
    unwind_sp_o = fp_i + FRAME;
    we_o        = !is_ret_o;
    if (is_ret_o) begin
      addr_o  = phase_i ? (fp_i + STEP) : fp_i;
      wdata_o = '0;
    end else begin
      // slot at sp-STEP is skipped on purpose
      addr_o  = phase_i ? frame_top_o : (sp_i - STEP2);
      wdata_o = phase_i ? fp_i : ret_addr;
    end
  end
endmodule

// File: rtl/frame_ctrl.sv
module frame_ctrl
  import frame_seq_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  frame_kind_e   kind_i,
  input  logic [DW-1:0] pc_i,
  input  logic [DW-1:0] sp_i,
  input  logic [DW-1:0] fp_i,
  input  logic [DW-1:0] target_i,
  input  logic [DW-1:0] handler_i,
  input  logic          mem_ready_i,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          is_ret_i,
  input  logic [DW-1:0] frame_top_i,
  input  logic [DW-1:0] unwind_sp_i,
  output frame_kind_e   kind_q_o,
  output logic [DW-1:0] pc_q_o,
  output logic [DW-1:0] sp_q_o,
  output logic [DW-1:0] fp_q_o,
  output logic          phase_o,
  output logic          req_o,
  output logic          idle_o,
  output logic          done_o,
  output logic [DW-1:0] sp_o,
  output logic [DW-1:0] fp_o,
  output logic [DW-1:0] pc_o
);
  frame_state_e  state_q, state_d;
  logic [DW-1:0] dest_q;
  logic [DW-1:0] fp_ld_q;
  logic          accept;

  assign accept  = (state_q == ST_IDLE) && start_i;
  assign req_o   = (state_q == ST_ACC0) || (state_q == ST_ACC1);
  assign idle_o  = (state_q == ST_IDLE);
  assign done_o  = (state_q == ST_DONE);
  assign phase_o = (state_q == ST_ACC1);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_ACC0;
      ST_ACC0: if (mem_ready_i) state_d = ST_ACC1;
      ST_ACC1: if (mem_ready_i) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // operand capture at start only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q_o <= KIND_CALL_REG;
      pc_q_o   <= '0;
      sp_q_o   <= '0;
      fp_q_o   <= '0;
      dest_q   <= '0;
    end else if (accept) begin
      kind_q_o <= kind_i;
      pc_q_o   <= pc_i;
      sp_q_o   <= sp_i;
      fp_q_o   <= fp_i;
      dest_q   <= (kind_i == KIND_TRAP) ? handler_i : target_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fp_ld_q <= '0;
    else if (state_q == ST_ACC0 && mem_ready_i && is_ret_i) fp_ld_q <= mem_rdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_o <= '0;
      fp_o <= '0;
      pc_o <= '0;
    end else if (state_q == ST_ACC1 && mem_ready_i) begin
      if (is_ret_i) begin
        sp_o <= unwind_sp_i;
        fp_o <= fp_ld_q;
        pc_o <= mem_rdata_i;
      end else begin
        sp_o <= frame_top_i;
        fp_o <= frame_top_i;
        pc_o <= dest_q;
      end
    end
  end
endmodule

// File: rtl/call_frame_seq.sv
module call_frame_seq
  import frame_seq_pkg::*;
#(
  parameter int DW         = 32,
  parameter int WORD_BYTES = 4,
  parameter int SHORT_LEN  = 2,
  parameter int LONG_LEN   = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    kind_i,
  input  logic [DW-1:0] pc_i,
  input  logic [DW-1:0] sp_i,
  input  logic [DW-1:0] fp_i,
  input  logic [DW-1:0] target_i,
  input  logic [DW-1:0] handler_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_ready_i,
  output logic          done_o,
  output logic [DW-1:0] sp_o,
  output logic [DW-1:0] fp_o,
  output logic [DW-1:0] pc_o
);
  frame_kind_e   kind_q_w;
  logic [DW-1:0] pc_q_w, sp_q_w, fp_q_w;
  logic [DW-1:0] frame_top_w, unwind_sp_w;
  logic          phase_w, is_ret_w, idle_w, we_w;

  frame_ctrl #(.DW(DW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .kind_i      (frame_kind_e'(kind_i)),
    .pc_i        (pc_i),
    .sp_i        (sp_i),
    .fp_i        (fp_i),
    .target_i    (target_i),
    .handler_i   (handler_i),
    .mem_ready_i (mem_ready_i),
    .mem_rdata_i (mem_rdata_i),
    .is_ret_i    (is_ret_w),
    .frame_top_i (frame_top_w),
    .unwind_sp_i (unwind_sp_w),
    .kind_q_o    (kind_q_w),
    .pc_q_o      (pc_q_w),
    .sp_q_o      (sp_q_w),
    .fp_q_o      (fp_q_w),
    .phase_o     (phase_w),
    .req_o       (mem_req_o),
    .idle_o      (idle_w),
    .done_o      (done_o),
    .sp_o        (sp_o),
    .fp_o        (fp_o),
    .pc_o        (pc_o)
  );

  frame_calc #(
    .DW(DW), .WORD_BYTES(WORD_BYTES), .SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)
  ) u_calc (
    .kind_i      (kind_q_w),
    .phase_i     (phase_w),
    .pc_i        (pc_q_w),
    .sp_i        (sp_q_w),
    .fp_i        (fp_q_w),
    .is_ret_o    (is_ret_w),
    .we_o        (we_w),
    .addr_o      (mem_addr_o),
    .wdata_o     (mem_wdata_o),
    .frame_top_o (frame_top_w),
    .unwind_sp_o (unwind_sp_w)
  );

  assign mem_we_o = mem_req_o && we_w;
endmodule

// File: rtl/call_frame_seq_chk.sv
module call_frame_seq_chk #(
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          we_i,
  input logic          ready_i,
  input logic [DW-1:0] addr_i,
  input logic [DW-1:0] wdata_i,
  input logic          done_i,
  input logic          idle_i,
  input logic          is_ret_i
);
  // R7
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !ready_i |=> req_i && $stable(addr_i) && $stable(we_i) && $stable(wdata_i));

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  // R8
  done_after_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> $past(req_i && ready_i));

  // R6
  ret_read_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && is_ret_i |-> !we_i);

  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_i |-> !req_i && !done_i);
endmodule

bind call_frame_seq call_frame_seq_chk #(.DW(DW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (mem_req_o),
  .we_i    (mem_we_o),
  .ready_i (mem_ready_i),
  .addr_i  (mem_addr_o),
  .wdata_i (mem_wdata_o),
  .done_i  (done_o),
  .idle_i  (idle_w),
  .is_ret_i(is_ret_w)
);

// File: tb/call_frame_seq_test.sv
module call_frame_seq_test;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic        we;
    logic [31:0] addr;
    logic [31:0] data;
    string       tag;
  } acc_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  kind_i = 2'b00;
  logic [31:0] pc_i = '0, sp_i = '0, fp_i = '0, target_i = '0, handler_i = '0;
  logic        mem_req_o, mem_we_o, done_o;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic        mem_ready_i = 1'b0;
  logic [31:0] sp_o, fp_o, pc_o;

  logic [31:0] mem [256];
  acc_t        exp_q[$];
  int          n_chk = 0, n_fail = 0, n_done = 0, n_ops = 0;
  int          ready_mode = 0;
  int          cyc = 0;
  bit          finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  call_frame_seq uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .kind_i(kind_i),
    .pc_i(pc_i), .sp_i(sp_i), .fp_i(fp_i), .target_i(target_i), .handler_i(handler_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_ready_i(mem_ready_i),
    .done_o(done_o), .sp_o(sp_o), .fp_o(fp_o), .pc_o(pc_o)
  );

  assign mem_rdata_i = mem[mem_addr_o[9:2]];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // memory model and ready pattern
  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    forever begin
      @(posedge clk);
      cyc <= cyc + 1;
      if (mem_req_o && mem_we_o && mem_ready_i) mem[mem_addr_o[9:2]] <= mem_wdata_o;
      mem_ready_i <= (ready_mode == 0) ? 1'b1 : ((cyc % 3) == 2);
    end
  end

  // monitor: scoreboard of accesses and done pulses
  initial begin
    forever begin
      @(negedge clk);
      if (rst_ni && done_o) n_done++;
      if (rst_ni && mem_req_o && mem_ready_i) begin
        if (exp_q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R9 unexpected access: actual %h expected none", mem_addr_o);
        end else begin
          acc_t e;
          e = exp_q.pop_front();
          chk({e.tag, " we"}, {31'b0, mem_we_o}, {31'b0, e.we});
          chk({e.tag, " addr"}, mem_addr_o, e.addr);
          if (e.we) chk({e.tag, " wdata"}, mem_wdata_o, e.data);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  task automatic run_op(input logic [1:0] k, input logic [31:0] pc, sp, fp, tgt, hnd,
                        input logic [31:0] e_sp, e_fp, e_pc, input bit poke, input string tag);
    @(negedge clk);
    kind_i = k; pc_i = pc; sp_i = sp; fp_i = fp; target_i = tgt; handler_i = hnd;
    start_i = 1'b1;
    n_ops++;
    @(negedge clk);
    start_i = 1'b0;
    // R10: scramble operands once captured
    kind_i = ~k; pc_i = ~pc; sp_i = ~sp; fp_i = ~fp; target_i = ~tgt; handler_i = ~hnd;
    if (poke) begin
      @(negedge clk);
      kind_i = 2'b11; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    for (int t = 0; t < 60; t++) begin
      if (done_o) break;
      @(negedge clk);
    end
    chk({tag, " R8 done seen"}, {31'b0, done_o}, 32'd1);
    chk({tag, " R5 R6 R10 sp"}, sp_o, e_sp);
    chk({tag, " R5 R6 R10 fp"}, fp_o, e_fp);
    chk({tag, " R5 R6 R10 pc"}, pc_o, e_pc);
    if (poke) begin
      // start in the done cycle must be dropped
      kind_i = 2'b00; pc_i = 32'h10; sp_i = 32'h100; fp_i = 32'h100; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk({tag, " R9 no req after done-cycle start"}, {31'b0, mem_req_o}, 32'd0);
      chk({tag, " R9 R8 done low"}, {31'b0, done_o}, 32'd0);
    end else begin
      @(negedge clk);
      chk({tag, " R8 single-cycle done"}, {31'b0, done_o}, 32'd0);
    end
  endtask

  function automatic void push(logic we, logic [31:0] a, logic [31:0] d, string tag);
    acc_t e;
    e.we = we; e.addr = a; e.data = d; e.tag = tag;
    exp_q.push_back(e);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 done", {31'b0, done_o}, 32'd0);
    chk("R1 req", {31'b0, mem_req_o}, 32'd0);
    chk("R1 sp", sp_o, 32'd0);
    chk("R1 fp", fp_o, 32'd0);
    chk("R1 pc", pc_o, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", {31'b0, mem_req_o}, 32'd0);

    // zero-wait register-indirect call
    ready_mode = 0;
    mem[8'hBF] = 32'hDEADBEEF; // byte 0x2FC, the empty slot
    push(1'b1, 32'h2F8, 32'h102, "R2 R4 reg call ret addr");
    push(1'b1, 32'h2F4, 32'h3F0, "R3 reg call saved fp");
    run_op(2'b00, 32'h100, 32'h300, 32'h3F0, 32'h2000, 32'h0,
           32'h2F4, 32'h2F4, 32'h2000, 0, "regcall");
    chk("R2 empty slot untouched", mem[8'hBF], 32'hDEADBEEF);

    // zero-wait return of that frame
    push(1'b0, 32'h2F4, 32'h0, "R6 ret read fp");
    push(1'b0, 32'h2F8, 32'h0, "R6 ret read ra");
    run_op(2'b11, 32'h0, 32'h111, 32'h2F4, 32'h0, 32'h0,
           32'h300, 32'h3F0, 32'h102, 0, "ret0");

    // slow memory, absolute call, with starts while busy
    ready_mode = 1;
    push(1'b1, 32'h1F8, 32'h46, "R2 R4 R7 abs call ret addr");
    push(1'b1, 32'h1F4, 32'h280, "R3 R7 abs call saved fp");
    run_op(2'b01, 32'h40, 32'h200, 32'h280, 32'h8000, 32'h0,
           32'h1F4, 32'h1F4, 32'h8000, 1, "abscall");

    // trap nested on top
    push(1'b1, 32'h1EC, 32'h66, "R2 R4 trap ret addr");
    push(1'b1, 32'h1E8, 32'h1F4, "R3 trap saved fp");
    run_op(2'b10, 32'h60, 32'h1F4, 32'h1F4, 32'h1234, 32'hA000,
           32'h1E8, 32'h1E8, 32'hA000, 1, "trap");

    // unwind both
    push(1'b0, 32'h1E8, 32'h0, "R6 R7 unwind trap fp");
    push(1'b0, 32'h1EC, 32'h0, "R6 R7 unwind trap ra");
    run_op(2'b11, 32'h0, 32'h1E8, 32'h1E8, 32'h0, 32'h0,
           32'h1F4, 32'h1F4, 32'h66, 0, "ret1");
    push(1'b0, 32'h1F4, 32'h0, "R6 unwind call fp");
    push(1'b0, 32'h1F8, 32'h0, "R6 unwind call ra");
    run_op(2'b11, 32'h0, 32'h1F4, 32'h1F4, 32'h0, 32'h0,
           32'h200, 32'h280, 32'h46, 0, "ret2");

    repeat (6) @(negedge clk);
    chk("R9 scoreboard drained", exp_q.size(), 32'd0);
    chk("R8 R9 done count", n_done, n_ops);
    report();
  end
endmodule